// File: doc/BRIEF.md
# Parallel Flash Bus Operation Decoder

This block is the pin-facing front end of a parallel NOR-style flash model. It samples the chip-select, output-enable, write-enable, hardware-reset and word/byte-select pins on the system clock. From their levels it picks one bus operation: read, write, standby, output disable or reset. It drives a 16-bit data bus through separate data and per-bit enable outputs, so the pad ring can float any bit whose enable is low.

In word mode a read returns a whole 16-bit word. In byte mode only the low eight data bits are driven, and data pin 15 is taken as an input that supplies the lowest byte-address bit. That bit selects one half of the addressed word. Bus writes never reach the array. Each one is captured into a command latch that reports it with a single-cycle strobe when the write cycle ends. The array is a small register file that is loaded with a computed pattern at reset.

The command output is a pure strobe with no back-pressure. A bus write cycle cannot be stalled, so the consumer must accept each `cmd_valid` pulse in the cycle it appears. The captured fields hold their values until the next completed write.

Top module: `flash_bus_front`

## Requirements
- R1: When reset pin high, chip select low, output enable low and write enable high in word mode (`word_sel`=1), `dq_oe` is 16'hFFFF and `dq_out` carries the addressed word. The array is indexed by `addr_in[7:0]`, and the remaining address bits do not affect the read.
- R2: The same read in byte mode (`word_sel`=0) gives `dq_oe` = 16'h00FF and `dq_out[15:8]` = 0. `dq_out[7:0]` is the low byte of the word when `dq_in[15]` is 0 and the high byte when it is 1.
- R3: When chip select is high and the reset pin is high, every enable in `dq_oe` is 0 and `op` reads 0 (standby), whatever the other pins are.
- R4: When chip select is low and both output enable and write enable are high, `dq_oe` is 0 and `op` reads 3 (output disable).
- R5: When the reset pin is low, `dq_oe` is 0 and `op` reads 4. A write cycle cut short by the reset pin raises no strobe, and `array_mode` returns to 1.
- R6: A write cycle is chip select low, write enable low and output enable high. During it `dq_oe` is 0 and `op` reads 2. When it ends because write enable or chip select rises, `cmd_valid` is high for exactly one cycle, and `cmd_addr`/`cmd_data` show the last address and data seen in the cycle.
- R7: In byte mode a write captures `cmd_data` = {8'h00, `dq_in[7:0]`}, `cmd_lsb` = `dq_in[15]` and `cmd_byte` = 1. In word mode it captures all 16 data bits, with `cmd_lsb` = 0 and `cmd_byte` = 0.
- R8: After reset, array word i holds {i[7:0] ^ 8'hA5, i[7:0]}. Bus writes never change the array.
- R9: `array_mode` is 1 after reset and stays 1 until a write completes, which sets it to 0. While it is 0, reads return `cmd_data` in place of array data, with the same word/byte selection as R1/R2.
- R10: Chip select, output enable and write enable all low together is treated as output disable: `op` reads 3, `dq_oe` is 0, and no strobe follows.
- R11: `op` encodes standby=0, read=1, write=2, output disable=3, reset=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| word_sel | input | 1 | 1 = word mode, 0 = byte mode |
| addr_in | input | 19 | Word address |
| dq_in | input | 16 | Data pins as seen from the bus; bit 15 is the byte-half select in byte mode |
| dq_out | output | 16 | Data driven toward the bus |
| dq_oe | output | 16 | Per-bit drive enable for `dq_out` |
| op | output | 3 | Decoded operation code |
| array_mode | output | 1 | 1 while reads return array data |
| cmd_valid | output | 1 | One-cycle strobe at the end of a write cycle |
| cmd_addr | output | 19 | Word address captured by the last write |
| cmd_lsb | output | 1 | Byte-half bit captured by the last write |
| cmd_byte | output | 1 | Last write was made in byte mode |
| cmd_data | output | 16 | Data captured by the last write |

## Verification
Pins pass through one register stage, and every output is registered after it. So `dq_out`, `dq_oe`, `op` and `array_mode` reflect pin levels two rising edges after they are applied. `cmd_valid` rises two edges after the pin change that ends a write and falls one edge later. The bench drives pins on a falling edge and waits two rising edges before it samples on the next falling edge. It also samples the cycle after a strobe to confirm the strobe has dropped. The assertions compare outputs against pin levels taken two cycles back, which matches the same two-stage latency.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;

  typedef enum logic [2:0] {
    OP_STANDBY = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_OUTDIS  = 3'd3,
    OP_RESET   = 3'd4
  } op_e;

  typedef struct packed {
    logic              sel_n;
    logic              rd_n;
    logic              wr_n;
    logic              hw_rst_n;
    logic              word_sel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dq;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sel_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                  hw_rst_n: 1'b1, word_sel: 1'b1,
                                  addr: '0, dq: '0};

  function automatic logic [DATA_W-1:0] preload_word(input int unsigned idx);
    logic [BYTE_W-1:0] b;
    b = BYTE_W'(idx);
    return {b ^ BYTE_W'(8'hA5), b};
  endfunction
endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync
  import flash_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t pins_in,
  output pins_t pins_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= PINS_IDLE;
    else        pins_q <= pins_in;
  end
endmodule

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_bus_pkg::*;
(
  input  logic sel_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic hw_rst_n,
  output op_e  op
);
  always_comb begin
    if (!hw_rst_n)          op = OP_RESET;
    else if (sel_n)         op = OP_STANDBY;
    else if (!wr_n && rd_n) op = OP_WRITE;
    else if (!rd_n && wr_n) op = OP_READ;
    else                    op = OP_OUTDIS;
  end
endmodule

// File: rtl/flash_word_store.sv
module flash_word_store
  import flash_bus_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= preload_word(g);
      else        mem[g] <= mem[g];
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/flash_cmd_latch.sv
module flash_cmd_latch
  import flash_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              word_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_lsb,
  output logic              cmd_byte,
  output logic [DATA_W-1:0] cmd_data,
  output logic              array_mode
);
  logic              wr_d;
  logic [ADDR_W-1:0] sh_addr;
  logic              sh_lsb;
  logic              sh_byte;
  logic [DATA_W-1:0] sh_data;
  logic              wr_now;
  logic              done;

  assign wr_now = (op == OP_WRITE);
  assign done   = wr_d && !wr_now && (op != OP_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d    <= 1'b0;
      sh_addr <= '0;
      sh_lsb  <= 1'b0;
      sh_byte <= 1'b0;
      sh_data <= '0;
    end else begin
      wr_d <= wr_now;
      if (wr_now) begin
        sh_addr <= addr;
        sh_byte <= !word_sel;
        sh_lsb  <= word_sel ? 1'b0 : dq[DATA_W-1];
        sh_data <= word_sel ? dq : {{BYTE_W{1'b0}}, dq[BYTE_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      cmd_addr   <= '0;
      cmd_lsb    <= 1'b0;
      cmd_byte   <= 1'b0;
      cmd_data   <= '0;
      array_mode <= 1'b1;
    end else begin
      cmd_valid <= done;
      if (done) begin
        cmd_addr <= sh_addr;
        cmd_lsb  <= sh_lsb;
        cmd_byte <= sh_byte;
        cmd_data <= sh_data;
      end
      if (op == OP_RESET) array_mode <= 1'b1;
      else if (done)      array_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_bus_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              hw_rst_n,
  input  logic              word_sel,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic [2:0]        op,
  output logic              array_mode,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_lsb,
  output logic              cmd_byte,
  output logic [DATA_W-1:0] cmd_data
);
  pins_t             pins_in;
  pins_t             pins_q;
  op_e               op_now;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] src_word;
  logic [DATA_W-1:0] nxt_out;
  logic [DATA_W-1:0] nxt_oe;

  assign pins_in = '{sel_n: sel_n, rd_n: rd_n, wr_n: wr_n, hw_rst_n: hw_rst_n,
                     word_sel: word_sel, addr: addr_in, dq: dq_in};

  flash_pin_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_in (pins_in),
    .pins_q  (pins_q)
  );

  flash_op_decode u_dec (
    .sel_n    (pins_q.sel_n),
    .rd_n     (pins_q.rd_n),
    .wr_n     (pins_q.wr_n),
    .hw_rst_n (pins_q.hw_rst_n),
    .op       (op_now)
  );

  flash_word_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (pins_q.addr[IDX_W-1:0]),
    .rd_word (rd_word)
  );

  flash_cmd_latch u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op_now),
    .word_sel   (pins_q.word_sel),
    .addr       (pins_q.addr),
    .dq         (pins_q.dq),
    .cmd_valid  (cmd_valid),
    .cmd_addr   (cmd_addr),
    .cmd_lsb    (cmd_lsb),
    .cmd_byte   (cmd_byte),
    .cmd_data   (cmd_data),
    .array_mode (array_mode)
  );

  assign src_word = array_mode ? rd_word : cmd_data;

  always_comb begin
    nxt_out = '0;
    nxt_oe  = '0;
    if (op_now == OP_READ) begin
      if (pins_q.word_sel) begin
        nxt_out = src_word;
        nxt_oe  = '1;
      end else begin
        nxt_out[BYTE_W-1:0] = pins_q.dq[DATA_W-1] ? src_word[DATA_W-1:BYTE_W]
                                                  : src_word[BYTE_W-1:0];
        nxt_oe[BYTE_W-1:0]  = '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= '0;
      op     <= OP_STANDBY;
    end else begin
      dq_out <= nxt_out;
      dq_oe  <= nxt_oe;
      op     <= op_now;
    end
  end
endmodule

// File: rtl/flash_bus_front_chk.sv
module flash_bus_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic        hw_rst_n,
  input logic        word_sel,
  input logic [15:0] dq_oe,
  input logic        cmd_valid
);
  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_n, 2) && $past(hw_rst_n, 2)) |-> (dq_oe == 16'h0000)); // R3

  AST_RESET_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hw_rst_n, 2) |-> (dq_oe == 16'h0000 && !cmd_valid)); // R5

  AST_BYTE_UPPER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(word_sel, 2) |-> (dq_oe[15:8] == 8'h00)); // R2

  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 16'h0000 || dq_oe == 16'h00FF || dq_oe == 16'hFFFF)); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R6

  AST_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !(!$past(sel_n, 2) && !$past(wr_n, 2) && $past(rd_n, 2)
                    && $past(hw_rst_n, 2))); // R6
endmodule

bind flash_bus_front flash_bus_front_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .hw_rst_n  (hw_rst_n),
  .word_sel  (word_sel),
  .dq_oe     (dq_oe),
  .cmd_valid (cmd_valid)
);

// File: tb/flash_bus_front_bench.sv
`timescale 1ns/100ps
module flash_bus_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hw_rst_n = 1'b1, word_sel = 1'b1;
  logic [18:0] addr_in = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe, cmd_data;
  logic [2:0]  op;
  logic        array_mode, cmd_valid, cmd_lsb, cmd_byte;
  logic [18:0] cmd_addr;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  flash_bus_front u_flash_bus_front (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .hw_rst_n(hw_rst_n), .word_sel(word_sel), .addr_in(addr_in), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .op(op), .array_mode(array_mode),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_lsb(cmd_lsb),
    .cmd_byte(cmd_byte), .cmd_data(cmd_data)
  );

  function automatic logic [15:0] pattern(input logic [18:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic w, input logic h,
                       input logic ws, input logic [18:0] a, input logic [15:0] d);
    sel_n = s; rd_n = r; wr_n = w; hw_rst_n = h; word_sel = ws; addr_in = a; dq_in = d;
  endtask

  task automatic settle;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R3 reset oe", dq_oe, 16'h0);
    chk("R11 reset op", op, 3'd0);
    chk("R9 reset array_mode", array_mode, 1'b1);
    chk("R6 reset strobe", cmd_valid, 1'b0);
  endtask

  task automatic t_word_read;
    logic [18:0] al [4] = '{19'h00000, 19'h00012, 19'h000FF, 19'h7FF37};
    for (int i = 0; i < 4; i++) begin
      drive(0, 0, 1, 1, 1, al[i], 16'h0);
      settle();
      chk("R1 word oe", dq_oe, 16'hFFFF);
      chk("R8 word data", dq_out, pattern(al[i]));
      chk("R11 read op", op, 3'd1);
    end
  endtask

  task automatic t_byte_read;
    for (int h = 0; h < 2; h++) begin
      drive(0, 0, 1, 1, 0, 19'h00021, {h[0], 15'h7FFF});
      settle();
      chk("R2 byte oe", dq_oe, 16'h00FF);
      chk("R2 byte data", dq_out, h == 0 ? {8'h00, pattern(19'h21) & 16'h00FF}
                                           : {8'h00, pattern(19'h21) >> 8});
    end
  endtask

  task automatic t_standby;
    drive(1, 0, 1, 1, 1, 19'h5, 16'h0);
    settle();
    chk("R3 standby oe", dq_oe, 16'h0);
    chk("R3 standby op", op, 3'd0);
    drive(1, 1, 0, 1, 0, 19'h5, 16'h0);
    settle();
    chk("R3 standby write pins oe", dq_oe, 16'h0);
    drive(1, 1, 1, 1, 1, 19'h5, 16'h0);
    settle();
    chk("R3 standby no strobe", cmd_valid, 1'b0);
  endtask

  task automatic t_outdis;
    drive(0, 1, 1, 1, 1, 19'h9, 16'h0);
    settle();
    chk("R4 outdis oe", dq_oe, 16'h0);
    chk("R4 outdis op", op, 3'd3);
  endtask

  task automatic t_both_low;
    drive(0, 0, 0, 1, 1, 19'h9, 16'h1234);
    settle();
    chk("R10 both low oe", dq_oe, 16'h0);
    chk("R10 both low op", op, 3'd3);
    drive(0, 1, 1, 1, 1, 19'h9, 16'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 no strobe", cmd_valid, 1'b0);
    end
    chk("R10 mode kept", array_mode, 1'b1);
  endtask

  task automatic t_reset_pin;
    drive(0, 0, 1, 0, 1, 19'h3, 16'h0);
    settle();
    chk("R5 reset pin oe", dq_oe, 16'h0);
    chk("R11 reset op", op, 3'd4);
  endtask

  task automatic t_write_abort;
    drive(0, 1, 0, 1, 1, 19'h77, 16'hAAAA);
    settle();
    chk("R6 write op", op, 3'd2);
    drive(0, 1, 0, 0, 1, 19'h77, 16'hAAAA);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 aborted no strobe", cmd_valid, 1'b0);
    end
    drive(0, 1, 1, 1, 1, 19'h77, 16'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 no strobe after", cmd_valid, 1'b0);
    end
    chk("R5 mode after abort", array_mode, 1'b1);
  endtask

  task automatic t_write_word;
    drive(0, 1, 0, 1, 1, 19'h15500, 16'h0001);
    @(negedge clk);
    drive(0, 1, 0, 1, 1, 19'h00155, 16'hBEEF);
    settle();
    chk("R6 write oe", dq_oe, 16'h0);
    chk("R6 no early strobe", cmd_valid, 1'b0);
    drive(0, 1, 1, 1, 1, 19'h00155, 16'h0);
    settle();
    chk("R6 strobe", cmd_valid, 1'b1);
    chk("R6 addr", cmd_addr, 19'h00155);
    chk("R7 word data", cmd_data, 16'hBEEF);
    chk("R7 word lsb", cmd_lsb, 1'b0);
    chk("R7 word flag", cmd_byte, 1'b0);
    chk("R9 mode cleared", array_mode, 1'b0);
    @(negedge clk);
    chk("R6 strobe one cycle", cmd_valid, 1'b0);
    drive(0, 0, 1, 1, 1, 19'h10, 16'h0);
    settle();
    chk("R9 word echo", dq_out, 16'hBEEF);
    drive(0, 0, 1, 1, 0, 19'h10, 16'h8000);
    settle();
    chk("R9 byte echo", dq_out, 16'h00BE);
  endtask

  task automatic t_write_byte;
    drive(0, 1, 0, 1, 0, 19'h00055, 16'hFF5A);
    settle();
    drive(1, 1, 0, 1, 0, 19'h00055, 16'hFF5A);
    settle();
    chk("R6 strobe on select rise", cmd_valid, 1'b1);
    chk("R7 byte data", cmd_data, 16'h005A);
    chk("R7 byte lsb", cmd_lsb, 1'b1);
    chk("R7 byte flag", cmd_byte, 1'b1);
    chk("R6 byte addr", cmd_addr, 19'h00055);
    @(negedge clk);
    chk("R6 byte strobe one cycle", cmd_valid, 1'b0);
    drive(1, 1, 1, 0, 1, 19'h0, 16'h0);
    settle();
    chk("R5 mode restored", array_mode, 1'b1);
    drive(0, 0, 1, 1, 1, 19'h00055, 16'h0);
    settle();
    chk("R8 array untouched", dq_out, pattern(19'h55));
    drive(0, 0, 1, 1, 1, 19'h00155, 16'h0);
    settle();
    chk("R8 array untouched word", dq_out, pattern(19'h155));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_word_read();
    t_byte_read();
    t_standby();
    t_outdis();
    t_both_low();
    t_reset_pin();
    t_write_abort();
    t_write_word();
    t_write_byte();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule